// File: doc/BRIEF.md
# Fourth-Order Sinc Decimator with Selectable State Clearing

This block turns the one-bit density stream of a delta-sigma modulator into signed 18-bit words at a rate lower by a factor of 2048. It has four cascaded accumulators running at the sample rate and four differencing stages running at the word rate. The resulting response is sinc to the fourth power. Its -3 dB corner lies near a quarter of the word rate. With a modulator ticking at roughly 246 kHz, this gives about 120 words per second. A one-valued bit counts as +1 and a zero-valued bit counts as -1. The full-precision sum is rounded to nearest and clipped to the 18-bit range.

A start strobe clears all filter state and latches one of two conversion styles. In one-shot style the block emits a single word once the filter has fully settled. It then wipes its state and falls idle until the next strobe. In free-running style it keeps its accumulated history. It emits one word every 2048 samples after the first settled word.

Top module: `sinc4_decimator`

## Requirements
- R1: While reset is active and in the first cycle after it, `result_valid` is 0 and `result` is 0.
- R2: After `start`, the sample taken in the strobe cycle is discarded. The first word is flagged by `result_valid` in the cycle after the 8192nd enabled sample (four decimation periods of 2048). In one-shot style (`cont_mode`=0 at the strobe), that word is the only one, and the block then goes idle.
- R3: Input bit 1 weighs +1 and bit 0 weighs -1. A settled all-ones stream gives 131071 (saturated), and a settled all-zeros stream gives -131072.
- R4: A settled periodic stream with a fraction p of ones yields round((2p-1)·131072). For example, 0x55 gives 0, 0x77 gives 65536, and 0x01 gives -98304, with the pattern byte sent LSB first and repeated.
- R5: In free-running style (`cont_mode`=1 at the strobe), words follow every 2048 enabled samples after the first one. History is kept: after an all-ones to all-zeros step, the word 2048 samples later is still positive, and the word 8192 samples later is exactly -131072.
- R6: A `start` during a running conversion discards all state. The next word again needs 8192 fresh enabled samples.
- R7: Cycles with `mod_en`=0 take no sample, whatever `mod_bit` does. Gaps between samples change neither the result nor the sample count at which it arrives.
- R8: The style is captured only at `start`. Changing `cont_mode` mid-conversion has no effect.
- R9: If `start` coincides with the sample that completes a settled decimation period, that word is still delivered from the old data. A new conversion begins with that sample discarded.
- R10: When idle (after reset or after a one-shot word), enabled samples produce no `result_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Sample strobe at the modulator rate |
| mod_bit | input | 1 | Modulator output bit, valid with `mod_en` |
| cont_mode | input | 1 | Style select captured at `start`: 0 one-shot, 1 free-running |
| start | input | 1 | Clears filter state and begins a conversion |
| result | output | 18 | Last word, two's complement, held between strobes |
| result_valid | output | 1 | One-cycle flag marking a new `result` |

## Verification
The delicate overlap is a `start` strobe arriving in the very cycle whose sample closes a settled decimation period. That single edge must both publish a word computed from the old state and clear every stage for a fresh conversion. The bench settles a free-running conversion on all-ones data. It then raises `start` together with the 2048th sample of the next period. It expects a word of 131071 right then. After that it expects silence until exactly 8192 further samples of all-zeros data have been fed, and then a word of -131072.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;
    localparam int unsigned CIC_ORDER = 4;

    typedef enum logic {
        CONV_ONESHOT = 1'b0,
        CONV_FREERUN = 1'b1
    } conv_style_e;
endpackage

// File: rtl/sinc4_integ.sv
module sinc4_integ #(
    parameter int ACC_W  = 46,
    parameter int STAGES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             din,
    output logic [ACC_W-1:0] tap
);
    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] acc;
    } integ_st_t;

    integ_st_t                    st_d, st_q;
    logic [STAGES-1:0][ACC_W-1:0] upd;

    // Registered chain: each stage adds the previous stage's stored value.
    always_comb begin
        upd[0] = st_q.acc[0] + (din ? ACC_W'(1) : {ACC_W{1'b1}});
        for (int k = 1; k < STAGES; k++) begin
            upd[k] = st_q.acc[k] + st_q.acc[k-1];
        end
        st_d = st_q;
        if (clr) begin
            st_d.acc = '0;
        end else if (en) begin
            st_d.acc = upd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tap = upd[STAGES-1];

    // R3: each taken sample moves the first accumulator by exactly +1 or -1
    a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=>
            (ACC_W'(st_q.acc[0] - $past(st_q.acc[0])) == ACC_W'(1) ||
             ACC_W'(st_q.acc[0] - $past(st_q.acc[0])) == {ACC_W{1'b1}}));

    // R7: without a sample and without a clear, no accumulator moves
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(st_q.acc));
endmodule

// File: rtl/sinc4_comb.sv
module sinc4_comb #(
    parameter int ACC_W  = 46,
    parameter int STAGES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             clr,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] dly;
    } comb_st_t;

    comb_st_t                   st_d, st_q;
    logic [STAGES:0][ACC_W-1:0] chain;

    always_comb begin
        chain[0] = din;
        for (int k = 0; k < STAGES; k++) begin
            chain[k+1] = chain[k] - st_q.dly[k];
        end
        st_d = st_q;
        if (fire) begin
            for (int k = 0; k < STAGES; k++) begin
                st_d.dly[k] = chain[k];
            end
        end
        if (clr) begin
            st_d.dly = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = chain[STAGES];

    // R5: difference memory changes only at a decimation instant or a clear
    a_r5_comb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !clr) |=> $stable(st_q.dly));
endmodule

// File: rtl/sinc4_outfmt.sv
module sinc4_outfmt #(
    parameter int ACC_W = 46,
    parameter int OUT_W = 18,
    parameter int SHIFT = 27
) (
    input  logic [ACC_W-1:0] full,
    output logic [OUT_W-1:0] word
);
    localparam logic signed [ACC_W:0] MAXV = (ACC_W+1)'((64'd1 << (OUT_W-1)) - 64'd1);
    localparam logic signed [ACC_W:0] MINV = -MAXV - (ACC_W+1)'(1);

    logic signed [ACC_W:0] sh;

    generate
        if (SHIFT > 0) begin : g_round
            localparam logic signed [ACC_W:0] HALF = (ACC_W+1)'(1) <<< (SHIFT-1);
            logic signed [ACC_W:0] rnd;
            always_comb begin
                rnd = $signed({full[ACC_W-1], full}) + HALF;
                sh  = rnd >>> SHIFT;
            end
        end else begin : g_pass
            always_comb sh = $signed({full[ACC_W-1], full});
        end
    endgenerate

    always_comb begin
        if (sh > MAXV)      word = MAXV[OUT_W-1:0];
        else if (sh < MINV) word = MINV[OUT_W-1:0];
        else                word = sh[OUT_W-1:0];
    end
endmodule

// File: rtl/sinc4_decimator.sv
module sinc4_decimator
    import sinc4_pkg::*;
#(
    parameter int DEC_LOG2 = 11,
    parameter int OUT_W    = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_en,
    input  logic             mod_bit,
    input  logic             cont_mode,
    input  logic             start,
    output logic [OUT_W-1:0] result,
    output logic             result_valid
);
    localparam int DEC      = 1 << DEC_LOG2;
    localparam int ACC_W    = CIC_ORDER * DEC_LOG2 + 2;
    localparam int SHIFT    = CIC_ORDER * DEC_LOG2 - (OUT_W - 1);
    localparam int SET_W    = $clog2(CIC_ORDER);
    localparam int SETTLE_N = CIC_ORDER * DEC;
    localparam int SINCE_W  = DEC_LOG2 + SET_W + 1;

    typedef struct packed {
        logic                busy;
        conv_style_e         style;
        logic [DEC_LOG2-1:0] phase;
        logic [SET_W-1:0]    settle;
        logic [OUT_W-1:0]    res;
        logic                vld;
    } ctl_t;

    ctl_t             c_d, c_q;
    logic             take, fire, good, wipe;
    logic [ACC_W-1:0] integ_tap, comb_out;
    logic [OUT_W-1:0] fmt_word;

    always_comb begin
        take = c_q.busy && mod_en;
        fire = take && (&c_q.phase);
        good = fire && (c_q.settle == SET_W'(CIC_ORDER - 1));
        wipe = start || (good && c_q.style == CONV_ONESHOT);

        c_d     = c_q;
        c_d.vld = good;
        if (good) c_d.res = fmt_word;
        if (take) c_d.phase = c_q.phase + DEC_LOG2'(1);
        if (fire && !good) c_d.settle = c_q.settle + SET_W'(1);
        if (good && c_q.style == CONV_ONESHOT) c_d.busy = 1'b0;
        if (start) begin
            c_d.busy   = 1'b1;
            c_d.style  = conv_style_e'(cont_mode);
            c_d.phase  = '0;
            c_d.settle = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    sinc4_integ #(.ACC_W(ACC_W), .STAGES(CIC_ORDER)) u_integ (
        .clk(clk), .rst_n(rst_n), .en(take), .clr(wipe), .din(mod_bit), .tap(integ_tap)
    );

    sinc4_comb #(.ACC_W(ACC_W), .STAGES(CIC_ORDER)) u_comb (
        .clk(clk), .rst_n(rst_n), .fire(fire), .clr(wipe), .din(integ_tap), .dout(comb_out)
    );

    sinc4_outfmt #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_fmt (
        .full(comb_out), .word(fmt_word)
    );

    assign result       = c_q.res;
    assign result_valid = c_q.vld;

    // Checker-only count of samples taken since the last start, saturating.
    logic [SINCE_W-1:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   since_q <= '0;
        else if (start)                               since_q <= '0;
        else if (take && since_q < SINCE_W'(SETTLE_N)) since_q <= since_q + SINCE_W'(1);
    end

    // R2: no word before the filter has seen four full periods
    a_r2_settled: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ($past(since_q) >= SINCE_W'(SETTLE_N - 1)));

    // R2: a one-shot word leaves the block idle unless a strobe intervened
    a_r2_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !$past(start) && $past(c_q.style) == CONV_ONESHOT) |-> !c_q.busy);

    // R7: a word always follows a taken sample
    a_r7_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(mod_en));

    // R8: style is frozen while running without a strobe
    a_r8_style_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.busy && !start) |=> $stable(c_q.style));

    // R10: idle block stays silent
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.busy |=> !result_valid);
endmodule

// File: tb/sinc4_decimator_tb.sv
module sinc4_decimator_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEC_LOG2   = 11;
    localparam int R          = 1 << DEC_LOG2;
    localparam int OUT_W      = 18;
    localparam int SETTLE     = 4 * R;
    localparam int POS_FS     = 131071;
    localparam int NEG_FS     = -131072;

    typedef struct packed {
        logic [7:0]  pat;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'hFF, 32'(POS_FS)},
        '{8'h00, 32'(NEG_FS)},
        '{8'h55, 32'(0)},
        '{8'h77, 32'(65536)},
        '{8'h01, -32'sd98304}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mod_en = 1'b0, mod_bit = 1'b0, cont_mode = 1'b0, start = 1'b0;
    logic [OUT_W-1:0] result;
    logic             result_valid;

    sinc4_decimator #(.DEC_LOG2(DEC_LOG2), .OUT_W(OUT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .mod_bit(mod_bit),
        .cont_mode(cont_mode), .start(start), .result(result), .result_valid(result_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int fed = 0, vcnt = 0, vat = 0, vlast = 0;

    always @(posedge clk) begin
        #1;
        if (result_valid) begin
            vcnt++;
            vlast = int'($signed(result));
            vat   = fed;
        end
    end

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_conv(input bit cont);
        @(negedge clk);
        start = 1'b1; cont_mode = cont; mod_en = 1'b0; fed = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(input logic [7:0] pat, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mod_en = 1'b1; mod_bit = pat[fed % 8]; fed++;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                mod_en = 1'b0; mod_bit = ~mod_bit;
            end
        end
        @(negedge clk);
        mod_en = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int v0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", result_valid == 1'b0, int'(result_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", result_valid == 1'b0, int'(result_valid), 0);
        check("R1 result after reset", result == '0, int'($signed(result)), 0);

        // R10: idle after reset ignores samples
        feed(8'hFF, 100, 0);
        check("R10 idle after reset", vcnt == 0, vcnt, 0);

        // R2 R3 R4: one-shot conversions over the vector table
        for (int t = 0; t < 5; t++) begin
            start_conv(1'b0);
            v0 = vcnt;
            feed(VECS[t].pat, SETTLE, 0);
            check("R2 one word", vcnt == v0 + 1, vcnt - v0, 1);
            check("R2 word at 4R samples", vat == SETTLE, vat, SETTLE);
            check("R3 R4 value", vlast == int'($signed(VECS[t].exp)), vlast, int'($signed(VECS[t].exp)));
            if (t == 0) begin
                feed(VECS[t].pat, R, 0);
                check("R10 idle after one-shot", vcnt == v0 + 1, vcnt - v0, 1);
            end
        end

        // R5: free-running keeps history across a step
        start_conv(1'b1);
        v0 = vcnt;
        feed(8'hFF, SETTLE, 0);
        check("R5 first word count", vcnt == v0 + 1, vcnt - v0, 1);
        check("R5 first word value", vlast == POS_FS, vlast, POS_FS);
        feed(8'h00, R, 0);
        check("R5 spacing", vcnt == v0 + 2 && vat == SETTLE + R, vat, SETTLE + R);
        check("R5 history kept", vlast > 0 && vlast < POS_FS, vlast, 1);
        feed(8'h00, 3 * R, 0);
        check("R5 word count", vcnt == v0 + 5, vcnt - v0, 5);
        check("R5 settled after step", vlast == NEG_FS, vlast, NEG_FS);

        // R6: restart mid-conversion
        start_conv(1'b1);
        feed(8'hFF, 1000, 0);
        start_conv(1'b1);
        v0 = vcnt;
        feed(8'h00, SETTLE - 1, 0);
        check("R6 no early word", vcnt == v0, vcnt - v0, 0);
        feed(8'h00, 1, 0);
        check("R6 word after restart", vcnt == v0 + 1 && vat == SETTLE, vat, SETTLE);
        check("R6 value", vlast == NEG_FS, vlast, NEG_FS);

        // R7: gapped sampling with toggling bit in gaps
        start_conv(1'b0);
        v0 = vcnt;
        feed(8'h77, SETTLE, 1);
        check("R7 gapped word", vcnt == v0 + 1 && vat == SETTLE, vat, SETTLE);
        check("R7 gapped value", vlast == 65536, vlast, 65536);

        // R8: style change mid-conversion ignored
        start_conv(1'b0);
        v0 = vcnt;
        feed(8'h55, 100, 0);
        cont_mode = 1'b1;
        feed(8'h55, SETTLE - 100, 0);
        check("R8 word value", vcnt == v0 + 1 && vlast == 0, vlast, 0);
        feed(8'h55, R, 0);
        check("R8 still one-shot", vcnt == v0 + 1, vcnt - v0, 1);
        cont_mode = 1'b0;

        // R9: start coinciding with a settled decimation sample
        start_conv(1'b1);
        feed(8'hFF, SETTLE + R - 1, 0);
        v0 = vcnt;
        @(negedge clk);
        mod_en = 1'b1; mod_bit = 1'b1; start = 1'b1; cont_mode = 1'b1; fed = 0;
        @(negedge clk);
        start = 1'b0; mod_en = 1'b0;
        check("R9 coincident word", vcnt == v0 + 1, vcnt - v0, 1);
        check("R9 coincident value", vlast == POS_FS, vlast, POS_FS);
        feed(8'h00, SETTLE, 0);
        check("R9 next word timing", vcnt == v0 + 2 && vat == SETTLE, vat, SETTLE);
        check("R9 next word value", vlast == NEG_FS, vlast, NEG_FS);

        summary();
        $finish;
    end
endmodule